// File: doc/BRIEF.md
# Audio Subframe Formatter

This block sits between an audio sample source and the word FIFO of a digital video transmitter's audio path. It takes a stream of 32-bit words, with channels interleaved in a fixed order, and rewrites each word into the 32-bit subframe layout that the FIFO expects. There are two modes. In linear PCM mode the block keeps the 24-bit sample. It adds a channel-status bit, a block-start flag and an even-parity bit, and it tracks its place in the 192-frame channel-status block itself. In pass-through mode the source already supplies complete IEC 60958 words, with the flag nibble on top and a preamble code in the bottom nibble. The block only moves the fields into place.

Software first loads the configuration while the stream is idle: the mode, the channel count and a 32-bit channel-status prefix. It then issues a stream start and feeds words under valid/ready flow control. A stop returns the block to idle so that it can be reconfigured. Each output word appears one cycle after its input word is accepted. Downstream backpressure holds the output word and stops intake.

Top module: `iec_subframe_fmt`

## Requirements
- R1: In PCM mode, output bits 23:0 equal input bits 23:0. Input bits 31:24 do not reach the output. Output bits 31:29, 25 and 24 are 0.
- R2: In PCM mode, output bit 26 carries the channel-status bit for the current frame number f and channel position c. For f below 32 it is bit f of the status prefix, except for f = 20..23, which carry bits 0..3 of the value c+1. For f from 32 to 191 it is 0.
- R3: In PCM mode, output bit 28 is 1 only on the word at channel position 0 of frame 0, and 0 on every other word.
- R4: In PCM mode, output bit 27 equals the XOR of output bits 26:0, so bits 27:0 hold an even number of ones.
- R5: The frame number advances by one after each group of N accepted words, where N is the configured channel count. It counts 0 to 191 and then wraps to 0.
- R6: A stream start issued while idle resets both the channel position and the frame number to 0.
- R7: In pass-through mode, output bits 27:0 equal input bits 31:4, output bit 28 equals input bit 3, and output bits 31:29 are 0.
- R8: A configuration write (mode bit: 0 = PCM, 1 = pass-through; channel count; status prefix) takes effect only while no stream is active. A write issued during a stream is dropped.
- R9: While out_valid is high and out_ready is low, out_data holds its value and in_ready is low. No accepted word is lost or duplicated.
- R10: A word accepted at a clock edge is presented on out_valid/out_data right after that edge, one cycle of latency.
- R11: While no stream is active, including during reset, in_ready is low and no word is taken.
- R12: A written channel count below 2 acts as 2, and a count above 8 acts as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_pass | input | 1 | Mode for the write: 0 PCM, 1 pass-through |
| cfg_chans | input | 4 | Channel count for the write (2..8) |
| cfg_status | input | 32 | Channel-status prefix for the write |
| strm_start | input | 1 | Start a stream (acted on when idle) |
| strm_stop | input | 1 | End the stream |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Formatted subframe word |
| out_ready | input | 1 | Downstream accepts the output word |

## Verification
Every result is due exactly one cycle after its input word is accepted. The expected word is queued when the word is driven and compared when it is handed out, at the falling edge before the handshake edge. The latency check samples out_valid three time units after the accepting edge. The stall check compares out_data at successive falling edges while out_ready is low. Counter effects such as frame wrap, restart and the clamped channel count are observed only through the output bits 26 and 28 of later words, and the block-start count is tallied over whole runs.

// File: rtl/iec_fmt_pkg.sv
package iec_fmt_pkg;

  typedef enum logic {
    FMT_PCM  = 1'b0,
    FMT_PASS = 1'b1
  } fmt_mode_e;

  localparam int STATUS_BITS = 32;
  localparam int CHNUM_LO    = 20;

  // Channel-status bit for one channel slot in one frame.
  function automatic logic status_bit(input logic [31:0] prefix,
                                      input logic [7:0]  ch,
                                      input logic [7:0]  frame);
    logic [3:0] chnum;
    logic [4:0] idx;
    chnum = ch[3:0] + 4'd1;
    idx   = frame[4:0];
    if (frame >= 8'(STATUS_BITS)) return 1'b0;
    if (idx >= 5'(CHNUM_LO) && idx <= 5'(CHNUM_LO + 3)) return chnum[idx[1:0]];
    return prefix[idx];
  endfunction

  function automatic logic [31:0] pack_pcm(input logic [31:0] smp,
                                           input logic        cs,
                                           input logic        blk);
    logic [31:0] w;
    w        = '0;
    w[23:0]  = smp[23:0];
    w[26]    = cs;
    w[28]    = blk;
    w[27]    = ^w[26:0];
    return w;
  endfunction

  function automatic logic [31:0] pack_pass(input logic [31:0] raw);
    logic [31:0] w;
    w     = raw >> 4;
    w[28] = raw[3];
    return w;
  endfunction

endpackage

// File: rtl/iec_seq_ctr.sv
module iec_seq_ctr #(
  parameter int CH_W   = 3,
  parameter int FRAMES = 192,
  parameter int FR_W   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  input  logic [CH_W-1:0] last_ch,
  output logic [CH_W-1:0] ch_q,
  output logic [FR_W-1:0] frame_q,
  output logic            frame_done
);
  localparam logic [FR_W-1:0] LAST_FRAME = FR_W'(FRAMES - 1);

  assign frame_done = adv && (ch_q == last_ch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q    <= '0;
      frame_q <= '0;
    end else if (clr) begin
      ch_q    <= '0;
      frame_q <= '0;
    end else if (adv) begin
      if (frame_done) begin
        ch_q    <= '0;
        frame_q <= (frame_q == LAST_FRAME) ? '0 : frame_q + 1'b1;
      end else begin
        ch_q <= ch_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/iec_word_pack.sv
module iec_word_pack
  import iec_fmt_pkg::*;
#(
  parameter int CH_W = 3,
  parameter int FR_W = 8
) (
  input  fmt_mode_e       mode,
  input  logic [31:0]     prefix,
  input  logic [CH_W-1:0] ch,
  input  logic [FR_W-1:0] frame,
  input  logic [31:0]     din,
  output logic [31:0]     dout,
  output logic            is_pcm
);
  logic cs_bit;
  logic blk_bit;

  assign cs_bit  = status_bit(prefix, 8'(ch), 8'(frame));
  assign blk_bit = (ch == '0) && (frame == '0);
  assign is_pcm  = (mode == FMT_PCM);

  always_comb begin
    if (is_pcm) dout = pack_pcm(din, cs_bit, blk_bit);
    else        dout = pack_pass(din);
  end
endmodule

// File: rtl/iec_out_stage.sv
module iec_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         pcm_in,
  input  logic         take,
  output logic         free,
  output logic         valid_q,
  output logic [W-1:0] data_q,
  output logic         pcm_q
);
  assign free = !valid_q || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      pcm_q   <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= din;
      pcm_q   <= pcm_in;
    end else if (take) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/iec_subframe_fmt.sv
module iec_subframe_fmt
  import iec_fmt_pkg::*;
#(
  parameter int MAX_CH = 8,
  parameter int FRAMES = 192,
  localparam int CH_W  = $clog2(MAX_CH),
  localparam int CNT_W = $clog2(MAX_CH + 1),
  localparam int FR_W  = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_pass,
  input  logic [CNT_W-1:0] cfg_chans,
  input  logic [31:0]      cfg_status,
  input  logic             strm_start,
  input  logic             strm_stop,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [31:0]      out_data,
  input  logic             out_ready
);
  fmt_mode_e       mode_q;
  logic [31:0]     prefix_q;
  logic [CH_W-1:0] last_ch_q;
  logic            active_q;
  logic [CH_W-1:0] cfg_last;

  // named internal events
  logic start_ok, cfg_ok, accept, stage_free;
  logic [CH_W-1:0] ch_q;
  logic [FR_W-1:0] frame_q;
  logic frame_done;
  logic [31:0] packed_w;
  logic pack_pcm_w, out_pcm_q;

  assign start_ok = strm_start && !active_q;
  assign cfg_ok   = cfg_wr && !active_q;
  assign in_ready = active_q && stage_free;
  assign accept   = in_valid && in_ready;

  always_comb begin
    if (cfg_chans < CNT_W'(2))           cfg_last = CH_W'(1);
    else if (cfg_chans > CNT_W'(MAX_CH)) cfg_last = CH_W'(MAX_CH - 1);
    else                                 cfg_last = CH_W'(cfg_chans - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= FMT_PCM;
      prefix_q  <= '0;
      last_ch_q <= CH_W'(1);
      active_q  <= 1'b0;
    end else begin
      if (cfg_ok) begin
        mode_q    <= cfg_pass ? FMT_PASS : FMT_PCM;
        prefix_q  <= cfg_status;
        last_ch_q <= cfg_last;
      end
      if (start_ok)       active_q <= 1'b1;
      else if (strm_stop) active_q <= 1'b0;
    end
  end

  iec_seq_ctr #(.CH_W(CH_W), .FRAMES(FRAMES), .FR_W(FR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .adv(accept),
    .last_ch(last_ch_q), .ch_q(ch_q), .frame_q(frame_q), .frame_done(frame_done)
  );

  iec_word_pack #(.CH_W(CH_W), .FR_W(FR_W)) u_pack (
    .mode(mode_q), .prefix(prefix_q), .ch(ch_q), .frame(frame_q),
    .din(in_data), .dout(packed_w), .is_pcm(pack_pcm_w)
  );

  iec_out_stage #(.W(32)) u_out (
    .clk(clk), .rst_n(rst_n), .load(accept), .din(packed_w), .pcm_in(pack_pcm_w),
    .take(out_ready), .free(stage_free), .valid_q(out_valid), .data_q(out_data),
    .pcm_q(out_pcm_q)
  );
endmodule

// File: rtl/iec_subframe_fmt_chk.sv
module iec_subframe_fmt_chk #(
  parameter int CH_W   = 3,
  parameter int FR_W   = 8,
  parameter int FRAMES = 192
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [31:0]     out_data,
  input logic            out_pcm,
  input logic            active_q,
  input logic            mode_q,
  input logic [31:0]     prefix_q,
  input logic [CH_W-1:0] last_ch_q,
  input logic            start_ok,
  input logic [CH_W-1:0] ch_q,
  input logic [FR_W-1:0] frame_q
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R9
  stall_intake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R10
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R11
  idle_intake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !in_ready);
  // R4
  even_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_pcm |-> !(^out_data[27:0]));
  // R5
  frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q < FR_W'(FRAMES) && ch_q <= last_ch_q);
  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> $stable(mode_q) && $stable(prefix_q) && $stable(last_ch_q));
  // R6
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> ch_q == '0 && frame_q == '0);
endmodule

bind iec_subframe_fmt iec_subframe_fmt_chk #(.CH_W(CH_W), .FR_W(FR_W), .FRAMES(FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_pcm(out_pcm_q), .active_q(active_q), .mode_q(mode_q), .prefix_q(prefix_q),
  .last_ch_q(last_ch_q), .start_ok(start_ok), .ch_q(ch_q), .frame_q(frame_q)
);

// File: tb/sim_iec_subframe_fmt.sv
`timescale 1ns/1ps
module sim_iec_subframe_fmt;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_pass = 1'b0, strm_start = 1'b0, strm_stop = 1'b0;
  logic [3:0] cfg_chans = 4'd2;
  logic [31:0] cfg_status = '0;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_ready;
  logic [31:0] out_data;

  always #5 clk = ~clk;

  iec_subframe_fmt u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pass(cfg_pass), .cfg_chans(cfg_chans),
    .cfg_status(cfg_status), .strm_start(strm_start), .strm_stop(strm_stop),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  int checks = 0, fails = 0, cyc = 0, blk_seen = 0;
  logic [31:0] qe[$];
  bit qp[$];
  int qn[$];
  bit m_pass = 0;
  int m_chans = 2, m_ch = 0, m_fr = 0, note_next = 0;
  logic [31:0] m_pre = '0;
  bit bp_on = 0, chk_lat = 0, held = 0;
  logic [31:0] held_data;
  logic [7:0] lfsr = 8'hA7;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_pcm(logic [31:0] s, int ch, int fr, logic [31:0] pre);
    logic [7:0] sb [4];
    logic [31:0] w;
    logic cs, blk;
    int ones = 0;
    for (int i = 0; i < 4; i++) sb[i] = pre[8*i +: 8];
    sb[2][7:4] = 4'(ch + 1);
    cs = (fr < 32) ? sb[fr/8][fr%8] : 1'b0;
    blk = (fr == 0 && ch == 0);
    w = {3'b000, blk, 1'b0, cs, 2'b00, s[23:0]};
    for (int b = 0; b < 27; b++) ones += int'(w[b]);
    w[27] = ones[0];
    return w;
  endfunction

  function automatic logic [31:0] model_pass(logic [31:0] s);
    return {3'b000, s[3], s[31:4]};
  endfunction

  task automatic send(input logic [31:0] d);
    qe.push_back(m_pass ? model_pass(d) : model_pcm(d, m_ch, m_fr, m_pre));
    qp.push_back(!m_pass);
    qn.push_back(note_next);
    note_next = 0;
    m_ch++;
    if (m_ch == m_chans) begin
      m_ch = 0;
      m_fr = (m_fr + 1) % 192;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    forever begin
      #2;
      if (in_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 in_valid = 1'b0;
    if (chk_lat) begin
      #2;
      // R10: word visible right after its accepting edge
      chk(out_valid === 1'b1, "R10 latency", {31'd0, out_valid}, 32'd1);
    end
  endtask

  task automatic cfg_raw(input bit pass, input logic [3:0] n, input logic [31:0] pre);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_pass = pass; cfg_chans = n; cfg_status = pre;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg(input bit pass, input logic [3:0] n, input logic [31:0] pre);
    cfg_raw(pass, n, pre);
    m_pass = pass; m_pre = pre;
    m_chans = (n < 2) ? 2 : (n > 8) ? 8 : int'(n);
  endtask

  task automatic start_pulse();
    @(negedge clk); strm_start = 1'b1;
    @(negedge clk); strm_start = 1'b0;
    m_ch = 0; m_fr = 0;
  endtask

  task automatic stop_pulse();
    @(negedge clk); strm_stop = 1'b1;
    @(negedge clk); strm_stop = 1'b0;
  endtask

  task automatic drain();
    while (qe.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = bp_on ? lfsr[0] : 1'b1;
      if (held) begin
        // R9: stalled word must be held
        chk(out_valid === 1'b1 && out_data === held_data, "R9 hold", out_data, held_data);
      end
      held = out_valid && !out_ready;
      held_data = out_data;
      if (out_valid && out_ready) begin
        if (qe.size() == 0) begin
          chk(1'b0, "R9 extra word", out_data, 32'd0);
        end else begin
          logic [31:0] e;
          bit p;
          int n;
          e = qe.pop_front(); p = qp.pop_front(); n = qn.pop_front();
          if (out_data[28] && p) blk_seen++;
          if (p) begin
            chk({out_data[31:29], out_data[25:0]} === {e[31:29], e[25:0]}, "R1 sample field", out_data, e);
            chk(out_data[26] === e[26], "R2 status bit", out_data, e);
            chk(out_data[28] === e[28], "R3 block start", out_data, e);
            chk(out_data[27] === e[27], "R4 parity", out_data, e);
          end else begin
            chk(out_data === e, "R7 pass-through", out_data, e);
          end
          if (n == 6) chk(out_data === e, "R6 restart word", out_data, e);
          if (n == 8) chk(out_data === e, "R8 ignored cfg word", out_data, e);
        end
      end
    end else begin
      out_ready = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(in_ready === 1'b0, "R11 reset in_ready", {31'd0, in_ready}, 32'd0);
    chk(out_valid === 1'b0, "R10 reset out_valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;

    // PCM, 2 channels
    cfg(1'b0, 4'd2, 32'hA5C3_0F96);
    start_pulse();
    chk_lat = 1;
    for (int i = 0; i < 4; i++) send($urandom);
    chk_lat = 0;
    bp_on = 1;
    for (int i = 0; i < 384; i++) send($urandom);
    drain();
    // R5: frames 0..193 hold two block starts
    chk(blk_seen == 2, "R5 block starts 2ch", blk_seen, 2);

    // R8: write during stream is dropped
    cfg_raw(1'b1, 4'd3, 32'h5A3C_F069);
    note_next = 8;
    for (int i = 0; i < 6; i++) send($urandom);
    drain();
    stop_pulse();

    // R11: idle block takes nothing
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'h1234_5678;
    #2 chk(in_ready === 1'b0, "R11 idle in_ready", {31'd0, in_ready}, 32'd0);
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R11 idle no output", {31'd0, out_valid}, 32'd0);
    in_valid = 1'b0;

    // PCM, count 15 clamps to 8 channels
    cfg(1'b0, 4'd15, 32'h0F0F_33CC);
    start_pulse();
    b0 = blk_seen;
    for (int i = 0; i < 1600; i++) send($urandom);
    drain();
    chk(blk_seen - b0 == 2, "R5 R12 block starts 8ch", blk_seen - b0, 2);

    // R6: restart mid-frame
    for (int i = 0; i < 3; i++) send($urandom);
    drain();
    stop_pulse();
    start_pulse();
    note_next = 6;
    for (int i = 0; i < 8; i++) send($urandom);
    drain();
    stop_pulse();

    // pass-through, 3 channels
    cfg(1'b1, 4'd3, 32'h0);
    start_pulse();
    for (int i = 0; i < 30; i++) send($urandom);
    send(32'hFFFF_FFF8);
    send(32'h0000_0007);
    drain();
    stop_pulse();

    summary();
    $finish;
  end
endmodule